// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches a set of external interrupt pins, from one up to thirty-two, and turns their activity into latched status bits. Software picks a trigger type for each line: a low level, a high level, a rising edge or a falling edge. The trigger type is spread over three bit-vector registers, one for the sense type, one for the edge direction and one for the level polarity. Every pin passes through a two-flop synchroniser before it is examined. Edges are found by comparing the synchronised value with its value one clock earlier.

Latched status bits are gated by a per-line mask. Any surviving bit raises the combined interrupt output. Line 0 also feeds a non-maskable interrupt output, which has its own enable bit and ignores the mask. Software sets mask bits through a write-one-to-set register and clears them through a write-one-to-clear register. It clears status bits through another write-one-to-clear register. Register bits for lines that are not built always read as zero, so software can write all ones to the sense-type register and count the lines that stick.

The bus is a plain single-cycle strobe. A write takes effect at the clock edge where `wr_en` is high. Read data is a combinational function of the address.

Top module: `xint_ctrl`

## Requirements
- R1: After reset the mask and status read 0, the sense-type register (offset 0x14) reads ones on every implemented line, the edge-direction (0x18) and level-polarity (0x1C) registers read 0, the NMI control register (0x24) reads 0, and both `irq_o` and `nmi_o` are low.
- R2: A write to offset 0x00 sets each mask bit whose write-data bit is 1. A write to offset 0x04 clears each mask bit whose write-data bit is 1. Zero data bits leave the mask unchanged. The mask reads back at offset 0x08.
- R3: Status reads back at offset 0x0C. A write to offset 0x10 clears each status bit whose data bit is 1, unless the line raises a new event in that same cycle.
- R4: A sense-type bit of 0 selects edge sensing. In that mode an edge-direction bit of 1 detects a rising edge and 0 detects a falling edge. A pin driven at a falling clock edge N shows in status at falling edge N+3 and not at N+2. The bit stays set until cleared. An edge in the same cycle as a clear keeps the bit set.
- R5: A sense-type bit of 1 selects level sensing. In that mode a level-polarity bit of 1 means active-high and 0 means active-low. The status bit is set while the level is active and cannot be cleared while the level is active. Once the level is gone the bit stays set until cleared.
- R6: Bits above the implemented line count read as 0 in the mask, status, sense-type, edge-direction and level-polarity registers, even after writing all ones.
- R7: `irq_o` is high exactly when some bit of status AND mask is 1.
- R8: Bit 0 of offset 0x24 enables `nmi_o`, which follows the status bit of line 0 whatever the mask holds. Writing 0 to that bit drives `nmi_o` low.
- R9: Reads of write-only offsets (0x00, 0x04, 0x10) and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | NUM_LINES | External interrupt pins, asynchronous |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_o | output | 1 | Combined maskable interrupt |
| nmi_o | output | 1 | Non-maskable interrupt from line 0 |

## Verification
A register write lands at the first rising edge under `wr_en`, so the bench reads it back at the following falling edge. A level-sensed line whose polarity write makes it active shows in status one edge after that. A pin change costs three rising edges: two synchroniser stages and the status flop. The bench drives pins at a falling edge and checks status at the next three falling edges, expecting 0, 0 and then the bit. For the race between a clear and a new edge, the bench raises the clear strobe exactly two falling edges after the pin change, so that both meet at the same rising edge. `irq_o`, `nmi_o` and `rdata` are combinational from registered state. Every expected value is queued by the driver and compared by the monitor shortly after a falling edge.

// File: rtl/xint_pkg.sv
package xint_pkg;
   // Byte offsets decoded by software; kept fixed.
   localparam int OFS_MASK_SET = 'h00;
   localparam int OFS_MASK_CLR = 'h04;
   localparam int OFS_MASK_RD  = 'h08;
   localparam int OFS_STATUS   = 'h0C;
   localparam int OFS_STAT_CLR = 'h10;
   localparam int OFS_SENSE    = 'h14;
   localparam int OFS_EDGE_DIR = 'h18;
   localparam int OFS_LVL_POL  = 'h1C;
   localparam int OFS_NMI_CTL  = 'h24;
   localparam int BUS_W        = 32;
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
   parameter int NUM_LINES = 32,
   parameter int STAGES    = 2,
   parameter bit RST_VAL   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] async_i,
   output logic [NUM_LINES-1:0] sync_o
);
   logic [STAGES-1:0][NUM_LINES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q[s] <= {NUM_LINES{RST_VAL}};
            end else if (s == 0) begin
               chain_q[s] <= async_i;
            end else begin
               chain_q[s] <= chain_q[(s > 0) ? s-1 : 0];
            end
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/xint_detect.sv
module xint_detect #(
   parameter int NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lvl_i,
   input  logic [NUM_LINES-1:0] sense_i,
   input  logic [NUM_LINES-1:0] edge_dir_i,
   input  logic [NUM_LINES-1:0] lvl_pol_i,
   output logic [NUM_LINES-1:0] evt_o
);
   logic [NUM_LINES-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= lvl_i;
   end

   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
         logic rise, fall, active;
         always_comb begin
            rise   = lvl_i[i] & ~prev_q[i];
            fall   = ~lvl_i[i] & prev_q[i];
            active = ~(lvl_i[i] ^ lvl_pol_i[i]);
            if (sense_i[i]) evt_o[i] = active;
            else            evt_o[i] = edge_dir_i[i] ? rise : fall;
         end
      end
   endgenerate
endmodule

// File: rtl/xint_regs.sv
module xint_regs
   import xint_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int ADDR_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [BUS_W-1:0]     wdata,
   input  logic [NUM_LINES-1:0] evt_i,
   output logic [BUS_W-1:0]     rdata,
   output logic [NUM_LINES-1:0] mask_q,
   output logic [NUM_LINES-1:0] status_q,
   output logic [NUM_LINES-1:0] sense_q,
   output logic [NUM_LINES-1:0] edge_dir_q,
   output logic [NUM_LINES-1:0] lvl_pol_q,
   output logic                 nmi_en_q
);
   logic [NUM_LINES-1:0] wd;
   logic                 hit_set, hit_mclr, hit_sclr, hit_sense, hit_edge, hit_pol, hit_nmi;
   logic [NUM_LINES-1:0] sclr_vec;

   assign wd        = wdata[NUM_LINES-1:0];
   assign hit_set   = wr_en && (addr == ADDR_W'(OFS_MASK_SET));
   assign hit_mclr  = wr_en && (addr == ADDR_W'(OFS_MASK_CLR));
   assign hit_sclr  = wr_en && (addr == ADDR_W'(OFS_STAT_CLR));
   assign hit_sense = wr_en && (addr == ADDR_W'(OFS_SENSE));
   assign hit_edge  = wr_en && (addr == ADDR_W'(OFS_EDGE_DIR));
   assign hit_pol   = wr_en && (addr == ADDR_W'(OFS_LVL_POL));
   assign hit_nmi   = wr_en && (addr == ADDR_W'(OFS_NMI_CTL));
   assign sclr_vec  = hit_sclr ? wd : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q     <= '0;
         status_q   <= '0;
         sense_q    <= '1;
         edge_dir_q <= '0;
         lvl_pol_q  <= '0;
         nmi_en_q   <= 1'b0;
      end else begin
         if (hit_set)   mask_q <= mask_q | wd;
         else if (hit_mclr) mask_q <= mask_q & ~wd;
         if (hit_sense) sense_q    <= wd;
         if (hit_edge)  edge_dir_q <= wd;
         if (hit_pol)   lvl_pol_q  <= wd;
         if (hit_nmi)   nmi_en_q   <= wdata[0];
         // A fresh event outranks a clear in the same cycle.
         status_q <= evt_i | (status_q & ~sclr_vec);
      end
   end

   function automatic logic [BUS_W-1:0] widen(input logic [NUM_LINES-1:0] v);
      logic [BUS_W-1:0] r;
      r = '0;
      r[NUM_LINES-1:0] = v;
      return r;
   endfunction

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(OFS_MASK_RD))       rdata = widen(mask_q);
      else if (addr == ADDR_W'(OFS_STATUS))   rdata = widen(status_q);
      else if (addr == ADDR_W'(OFS_SENSE))    rdata = widen(sense_q);
      else if (addr == ADDR_W'(OFS_EDGE_DIR)) rdata = widen(edge_dir_q);
      else if (addr == ADDR_W'(OFS_LVL_POL))  rdata = widen(lvl_pol_q);
      else if (addr == ADDR_W'(OFS_NMI_CTL))  rdata = {{(BUS_W-1){1'b0}}, nmi_en_q};
   end
endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
   import xint_pkg::*;
#(
   parameter int NUM_LINES   = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] pins_i,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [BUS_W-1:0]     wdata,
   output logic [BUS_W-1:0]     rdata,
   output logic                 irq_o,
   output logic                 nmi_o
);
   generate
      if (NUM_LINES < 1 || NUM_LINES > BUS_W) begin : g_bad_lines
         $error("xint_ctrl: NUM_LINES must lie in 1..32");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("xint_ctrl: ADDR_W must reach offset 0x24");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("xint_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NUM_LINES-1:0] pin_sync, evt;
   logic [NUM_LINES-1:0] mask_q, status_q, sense_q, edge_dir_q, lvl_pol_q;
   logic                 nmi_en_q;

   xint_sync #(.NUM_LINES(NUM_LINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(pins_i), .sync_o(pin_sync)
   );

   xint_detect #(.NUM_LINES(NUM_LINES)) u_detect (
      .clk(clk), .rst_n(rst_n), .lvl_i(pin_sync), .sense_i(sense_q),
      .edge_dir_i(edge_dir_q), .lvl_pol_i(lvl_pol_q), .evt_o(evt)
   );

   xint_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .evt_i(evt), .rdata(rdata), .mask_q(mask_q), .status_q(status_q),
      .sense_q(sense_q), .edge_dir_q(edge_dir_q), .lvl_pol_q(lvl_pol_q),
      .nmi_en_q(nmi_en_q)
   );

   assign irq_o = |(status_q & mask_q);
   assign nmi_o = nmi_en_q & status_q[0];
endmodule

// File: rtl/xint_ctrl_chk.sv
module xint_ctrl_chk
   import xint_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int ADDR_W    = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic [ADDR_W-1:0]    addr,
   input logic [BUS_W-1:0]     wdata,
   input logic [BUS_W-1:0]     rdata,
   input logic                 irq_o,
   input logic                 nmi_o,
   input logic [NUM_LINES-1:0] mask_q,
   input logic [NUM_LINES-1:0] status_q,
   input logic                 nmi_en_q
);
   logic [NUM_LINES-1:0] wd;
   assign wd = wdata[NUM_LINES-1:0];

   AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_MASK_SET)) |=> ((mask_q & $past(wd)) == $past(wd))); // R2
   AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_MASK_CLR)) |=> ((mask_q & $past(wd)) == '0)); // R2
   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == ADDR_W'(OFS_STAT_CLR)) |=> ((status_q & $past(status_q)) == $past(status_q))); // R4
   AST_SENSE_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(OFS_SENSE)) |-> ((rdata >> NUM_LINES) == '0)); // R6
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq_o); // R7
   AST_NMI_MASK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_en_q && status_q[0] && !mask_q[0]) |-> nmi_o); // R8
   AST_NMI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !nmi_en_q |-> !nmi_o); // R8
   AST_WRONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(OFS_STAT_CLR)) |-> (rdata == '0)); // R9
endmodule

bind xint_ctrl xint_ctrl_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .rdata(rdata), .irq_o(irq_o), .nmi_o(nmi_o), .mask_q(mask_q),
   .status_q(status_q), .nmi_en_q(nmi_en_q)
);

// File: tb/xint_ctrl_bench.sv
module xint_ctrl_bench;
   localparam int N  = 20;
   localparam int AW = 8;
   localparam logic [31:0] IMPL = 32'h000F_FFFF;
   localparam logic [7:0] A_SET = 8'h00, A_MCLR = 8'h04, A_MASK = 8'h08, A_STAT = 8'h0C,
                          A_SCLR = 8'h10, A_SENSE = 8'h14, A_EDGE = 8'h18, A_POL = 8'h1C,
                          A_NMI = 8'h24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pins = '1;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          irq_o, nmi_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct { int kind; logic [31:0] exp; string req; } item_t;
   item_t exp_q[$];

   xint_ctrl #(.NUM_LINES(N), .ADDR_W(AW)) u_xint_ctrl (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .nmi_o(nmi_o)
   );

   always #4ns clk = ~clk;

   // Monitor: compares queued expectations just after each falling edge.
   initial begin
      forever begin
         @(negedge clk);
         #1ns;
         while (exp_q.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it = exp_q.pop_front();
            got = (it.kind == 0) ? rdata : (it.kind == 1) ? {31'b0, irq_o} : {31'b0, nmi_o};
            checks++;
            if (got !== it.exp) begin
               errors++;
               $display("FAIL %s kind=%0d addr=%h actual=%h expected=%h",
                        it.req, it.kind, addr, got, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
      item_t it;
      @(negedge clk);
      addr = a;
      it.kind = 0; it.exp = e; it.req = req;
      exp_q.push_back(it);
      #2ns;
   endtask

   task automatic port(input int k, input logic e, input string req);
      item_t it;
      @(negedge clk);
      it.kind = k; it.exp = {31'b0, e}; it.req = req;
      exp_q.push_back(it);
      #2ns;
   endtask

   task automatic setpin(input int i, input logic v);
      @(negedge clk);
      pins[i] = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      rd(A_MASK, 32'h0, "R1 mask");
      rd(A_STAT, 32'h0, "R1 status");
      rd(A_SENSE, IMPL, "R1 sense");
      rd(A_EDGE, 32'h0, "R1 edge");
      rd(A_POL, 32'h0, "R1 pol");
      rd(A_NMI, 32'h0, "R1 nmi ctl");
      port(1, 1'b0, "R1 irq");
      port(2, 1'b0, "R1 nmi");
      // R6 unimplemented bits
      wr(A_SENSE, 32'hFFFF_FFFF); rd(A_SENSE, IMPL, "R6 sense");
      wr(A_EDGE, 32'hFFFF_FFFF);  rd(A_EDGE, IMPL, "R6 edge");
      wr(A_EDGE, 32'h0);
      wr(A_SET, 32'hFFFF_FFFF);   rd(A_MASK, IMPL, "R6 mask");
      wr(A_MCLR, 32'hFFFF_FFFF);  rd(A_MASK, 32'h0, "R2 mask all off");
      rd(A_STAT, 32'h0, "R6 status");
      // R2 set/clear of mask
      wr(A_SET, 32'h5);  rd(A_MASK, 32'h5, "R2 set");
      wr(A_SET, 32'h0);  rd(A_MASK, 32'h5, "R2 set zero");
      wr(A_MCLR, 32'h1); rd(A_MASK, 32'h4, "R2 clear");
      wr(A_MCLR, 32'h0); rd(A_MASK, 32'h4, "R2 clear zero");
      // R4 edge sensing: line 2 rising, line 3 falling
      wr(A_SENSE, 32'hFFFF3);
      wr(A_EDGE, 32'h4);
      setpin(2, 1'b0); idle(4);
      rd(A_STAT, 32'h0, "R4 wrong edge");
      setpin(2, 1'b1);
      rd(A_STAT, 32'h0, "R4 latency N+1");
      rd(A_STAT, 32'h0, "R4 latency N+2");
      rd(A_STAT, 32'h4, "R4 latency N+3");
      port(1, 1'b1, "R7 irq on");
      setpin(2, 1'b0); idle(4);
      rd(A_STAT, 32'h4, "R4 sticky");
      wr(A_SCLR, 32'h4);
      rd(A_STAT, 32'h0, "R3 clear");
      port(1, 1'b0, "R7 irq off");
      setpin(3, 1'b0); idle(4);
      rd(A_STAT, 32'h8, "R4 falling");
      port(1, 1'b0, "R7 masked");
      wr(A_SCLR, 32'h8);
      rd(A_STAT, 32'h0, "R3 clear falling");
      setpin(3, 1'b1); idle(4);
      rd(A_STAT, 32'h0, "R4 rising ignored");
      // R3/R4 edge wins over clear in the same cycle
      setpin(2, 1'b1);
      @(negedge clk);
      wr(A_SCLR, 32'h4);
      rd(A_STAT, 32'h4, "R3 edge beats clear");
      wr(A_SCLR, 32'h4);
      rd(A_STAT, 32'h0, "R3 clear after race");
      // R5 level sensing: line 5 active-high, line 6 active-low
      wr(A_POL, 32'h20);
      rd(A_STAT, 32'h20, "R5 high active");
      wr(A_SCLR, 32'h20);
      rd(A_STAT, 32'h20, "R5 clear blocked");
      setpin(5, 1'b0); idle(4);
      rd(A_STAT, 32'h20, "R5 held after level");
      wr(A_SCLR, 32'h20);
      rd(A_STAT, 32'h0, "R5 clear after level");
      setpin(6, 1'b0); idle(4);
      rd(A_STAT, 32'h40, "R5 low active");
      port(1, 1'b0, "R7 masked level");
      wr(A_SET, 32'h40);
      port(1, 1'b1, "R7 unmasked");
      wr(A_MCLR, 32'h40);
      port(1, 1'b0, "R7 remasked");
      setpin(6, 1'b1); idle(4);
      wr(A_SCLR, 32'h40);
      rd(A_STAT, 32'h0, "R5 low cleared");
      // R8 non-maskable output from line 0
      wr(A_NMI, 32'h1);
      rd(A_NMI, 32'h1, "R8 ctl");
      port(2, 1'b0, "R8 idle");
      setpin(0, 1'b0); idle(4);
      port(2, 1'b1, "R8 asserted");
      port(1, 1'b0, "R8 irq masked");
      rd(A_STAT, 32'h1, "R8 status");
      wr(A_NMI, 32'h0);
      port(2, 1'b0, "R8 disabled");
      rd(A_NMI, 32'h0, "R8 ctl off");
      wr(A_NMI, 32'h1);
      port(2, 1'b1, "R8 reenabled");
      setpin(0, 1'b1); idle(4);
      wr(A_SCLR, 32'h1);
      port(2, 1'b0, "R8 cleared");
      // R9 write-only and unmapped reads
      rd(A_SET, 32'h0, "R9 set reg");
      rd(A_MCLR, 32'h0, "R9 mclr reg");
      rd(A_SCLR, 32'h0, "R9 sclr reg");
      rd(8'h20, 32'h0, "R9 hole");
      rd(8'h3C, 32'h0, "R9 beyond");
      idle(2);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule